// File: doc/BRIEF.md
# Arcade Board I/O Port Controller

This block gathers the general-purpose I/O of an arcade main board behind one small register window. A host processor reaches eight byte-wide ports and one control register through a 5-bit offset and an 8-bit data path. Five of the ports are read-only inputs: two player-control ports, a service/coin port and two DIP-switch ports. All of these are active low, so a pressed control or a switch set to On reads as 0. One port is bidirectional, and its direction comes from a control bit. One port drives the board's coin meters, coin lockouts, flip-screen line and color/gray select. One port holds the two 4-bit tile bank nibbles.

The block also derives three signals from this state. It turns each rising edge of a coin-meter bit into a one-cycle increment pulse. It produces the active-low video blank by ORing a control bit with the tilemap generator's blank. It computes the tile ROM bank for the current tile from the per-tile select and the text-layer flag.

Top module: `arcade_io_ctrl`

## Requirements
- R1: After reset, the bidirectional latch, the misc output port, the tile bank register and the control register are all 0x00. As a result `ext_dir`, `vid2_en` and `meter_pulse` are 0.
- R2: Offsets 0x00 (player 1), 0x01 (player 2), 0x05 (DIP 1) and 0x06 (DIP 2) read their input pins unchanged, and a write to any of these offsets changes nothing.
- R3: Offset 0x04 returns the service/coin pins for bits 6:0, and bit 7 always reads as 1.
- R4: Offset 0x02 is the bidirectional port. Writes always load its latch, and `ext_out` always shows the latch. `ext_dir` equals control bit 0. A read returns `ext_in` when that bit is 0 and the latch when it is 1.
- R5: Offset 0x03 is the misc output port. It reads back what was written and drives `misc_out`. Bits 1:0 are the coin meters, bits 3:2 the coin lockouts, bit 5 flip (1 = flip) and bit 6 color (0 = grayscale).
- R6: `meter_pulse[i]` is high for exactly one cycle after a write that takes misc bit i from 0 to 1. A 1-to-1 or 1-to-0 write gives no pulse.
- R7: `blank_n` = control bit 1 OR `tgen_blank_n`, where 0 blanks the screen. `vid2_en` follows control bit 2.
- R8: Offset 0x08 is the control register. Bits 2:0 are stored and read back, and bits 7:3 read as 0.
- R9: The tile bank register is at offset 0x07, with bank 1 in bits 3:0 and bank 2 in bits 7:4. When `tile_sel` is 1 and `text_layer` is 0 the upper nibble is selected; otherwise the lower nibble is selected.
- R10: `tile_bank` is bits 2:0 of the selected nibble, or 0 when bit 3 of that nibble is set.
- R11: Offsets 0x09 to 0x1F read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| p1_in | input | 8 | Player 1 controls, active low |
| p2_in | input | 8 | Player 2 controls, active low |
| svc_in | input | 8 | Service/coin/start inputs, active low |
| dip1_in | input | 8 | DIP bank 1, 0 = On |
| dip2_in | input | 8 | DIP bank 2, 0 = On |
| ext_in | input | 8 | Connector value for the bidirectional port |
| ext_out | output | 8 | Bidirectional port latch |
| ext_dir | output | 1 | Connector direction, 1 = drive out |
| misc_out | output | 8 | Misc output port |
| meter_pulse | output | 2 | Coin-meter increment pulses |
| tgen_blank_n | input | 1 | Tilemap generator blank, active low |
| blank_n | output | 1 | Combined blank, 0 = blanked |
| vid2_en | output | 1 | Secondary video display enable |
| tile_sel | input | 1 | Per-tile nibble select |
| text_layer | input | 1 | Current tile belongs to the text layer |
| tile_bank | output | 3 | Effective tile ROM bank |

## Verification
The bench sweeps every tile bank byte against every combination of select and text flag, which covers two cases. A design that ignored the text flag would take the upper nibble for text tiles, and one that masked bit 3 instead of forcing zero would return banks 0 to 7 where 0 is expected. It also drives every old/new pair of coin-meter bits, so a level-triggered meter, a pulse lasting two cycles, or a pulse on a falling write would be seen. Input-port writes, unmapped writes and the direction switch are checked through read-back, which exposes a writable input port, a decode that aliases 0x08 upward, or a bidirectional read that ignores direction.

// File: rtl/aio_pkg.sv
package aio_pkg;
   // Register offsets; the bench and the brief rely on these values.
   localparam int OFS_P1    = 0;
   localparam int OFS_P2    = 1;
   localparam int OFS_BIDIR = 2;
   localparam int OFS_MISC  = 3;
   localparam int OFS_SVC   = 4;
   localparam int OFS_DIP1  = 5;
   localparam int OFS_DIP2  = 6;
   localparam int OFS_BANK  = 7;
   localparam int OFS_CTL   = 8;

   localparam int CTL_W = 3;

   typedef struct packed {
      logic vid2_en;   // bit 2
      logic show;      // bit 1, ORed into blank
      logic drive;     // bit 0, connector direction
   } ctl_t;
endpackage

// File: rtl/aio_regs.sv
module aio_regs
   import aio_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] bidir_q,
   output logic [PORT_W-1:0] misc_q,
   output logic [PORT_W-1:0] bank_q,
   output ctl_t              ctl_q
);
   localparam logic [ADDR_W-1:0] A_BIDIR = ADDR_W'(OFS_BIDIR);
   localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(OFS_MISC);
   localparam logic [ADDR_W-1:0] A_BANK  = ADDR_W'(OFS_BANK);
   localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFS_CTL);

   logic hit_bidir, hit_misc, hit_bank, hit_ctl;

   always_comb begin
      hit_bidir = wr_en && (addr == A_BIDIR);
      hit_misc  = wr_en && (addr == A_MISC);
      hit_bank  = wr_en && (addr == A_BANK);
      hit_ctl   = wr_en && (addr == A_CTL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bidir_q <= '0;
         misc_q  <= '0;
         bank_q  <= '0;
         ctl_q   <= '0;
      end else begin
         if (hit_bidir) bidir_q <= wdata;
         if (hit_misc)  misc_q  <= wdata;
         if (hit_bank)  bank_q  <= wdata;
         if (hit_ctl)   ctl_q   <= ctl_t'(wdata[CTL_W-1:0]);
      end
   end

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_CTL) |=> $stable(ctl_q)); // R8
   AST_MISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_MISC) |=> $stable(misc_q)); // R5
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_BANK) |=> $stable(bank_q)); // R9
endmodule

// File: rtl/aio_meter.sv
module aio_meter #(
   parameter int NUM_METERS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_METERS-1:0] lvl,
   output logic [NUM_METERS-1:0] pulse
);
   for (genvar i = 0; i < NUM_METERS; i++) begin : g_meter
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign pulse[i] = lvl[i] & ~prev_q;

      AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[i] |=> !pulse[i]); // R6
      AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         pulse[i] |-> lvl[i]); // R6
   end
endmodule

// File: rtl/aio_tilebank.sv
module aio_tilebank #(
   parameter int PORT_W = 8
) (
   input  logic              [PORT_W-1:0] bank_reg,
   input  logic                           sel,
   input  logic                           text,
   output logic [PORT_W/2-2:0]            bank
);
   localparam int NIB_W = PORT_W / 2;

   logic [NIB_W-1:0] nib;

   always_comb begin
      nib  = (sel && !text) ? bank_reg[PORT_W-1:NIB_W] : bank_reg[NIB_W-1:0];
      bank = nib[NIB_W-1] ? '0 : nib[NIB_W-2:0];
   end
endmodule

// File: rtl/arcade_io_ctrl.sv
module arcade_io_ctrl
   import aio_pkg::*;
#(
   parameter int PORT_W     = 8,
   parameter int ADDR_W     = 5,
   parameter int NUM_METERS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [PORT_W-1:0]       bus_wdata,
   output logic [PORT_W-1:0]       bus_rdata,
   input  logic [PORT_W-1:0]       p1_in,
   input  logic [PORT_W-1:0]       p2_in,
   input  logic [PORT_W-1:0]       svc_in,
   input  logic [PORT_W-1:0]       dip1_in,
   input  logic [PORT_W-1:0]       dip2_in,
   input  logic [PORT_W-1:0]       ext_in,
   output logic [PORT_W-1:0]       ext_out,
   output logic                    ext_dir,
   output logic [PORT_W-1:0]       misc_out,
   output logic [NUM_METERS-1:0]   meter_pulse,
   input  logic                    tgen_blank_n,
   output logic                    blank_n,
   output logic                    vid2_en,
   input  logic                    tile_sel,
   input  logic                    text_layer,
   output logic [PORT_W/2-2:0]     tile_bank
);
   localparam int BANK_W = PORT_W / 2 - 1;

   if (PORT_W < 8 || PORT_W % 2 != 0) begin : g_bad_width
      $error("PORT_W must be even and at least 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must reach the control offset");
   end
   if (NUM_METERS < 1 || NUM_METERS > 2) begin : g_bad_meters
      $error("NUM_METERS must be 1 or 2");
   end

   logic [PORT_W-1:0] bidir_q, misc_q, bank_q;
   ctl_t              ctl_q;

   aio_regs #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .bidir_q(bidir_q), .misc_q(misc_q),
      .bank_q(bank_q), .ctl_q(ctl_q)
   );

   aio_meter #(.NUM_METERS(NUM_METERS)) i_meter (
      .clk(clk), .rst_n(rst_n), .lvl(misc_q[NUM_METERS-1:0]),
      .pulse(meter_pulse)
   );

   aio_tilebank #(.PORT_W(PORT_W)) i_bank (
      .bank_reg(bank_q), .sel(tile_sel), .text(text_layer), .bank(tile_bank)
   );

   assign ext_out  = bidir_q;
   assign ext_dir  = ctl_q.drive;
   assign misc_out = misc_q;
   assign blank_n  = ctl_q.show | tgen_blank_n;
   assign vid2_en  = ctl_q.vid2_en;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_P1))         bus_rdata = p1_in;
      else if (bus_addr == ADDR_W'(OFS_P2))    bus_rdata = p2_in;
      else if (bus_addr == ADDR_W'(OFS_BIDIR)) bus_rdata = ctl_q.drive ? bidir_q : ext_in;
      else if (bus_addr == ADDR_W'(OFS_MISC))  bus_rdata = misc_q;
      else if (bus_addr == ADDR_W'(OFS_SVC))   bus_rdata = {1'b1, svc_in[PORT_W-2:0]};
      else if (bus_addr == ADDR_W'(OFS_DIP1))  bus_rdata = dip1_in;
      else if (bus_addr == ADDR_W'(OFS_DIP2))  bus_rdata = dip2_in;
      else if (bus_addr == ADDR_W'(OFS_BANK))  bus_rdata = bank_q;
      else if (bus_addr == ADDR_W'(OFS_CTL))   bus_rdata = PORT_W'(ctl_q);
   end

   AST_SVC_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_SVC)) |-> bus_rdata[PORT_W-1]); // R3
   AST_DIR_INPUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_BIDIR) && !ext_dir) |-> (bus_rdata == ext_in)); // R4
   AST_TEXT_LOW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (text_layer && bank_q[PORT_W/2-1]) |-> (tile_bank == BANK_W'(0))); // R10
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(OFS_CTL)) |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/test_arcade_io_ctrl.sv
`timescale 1ns/1ps
module test_arcade_io_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] p1_in = 8'hFF, p2_in = 8'hFF, svc_in = 8'hFF;
   logic [7:0] dip1_in = 8'hFF, dip2_in = 8'hFF, ext_in = 8'h00;
   logic [7:0] ext_out, misc_out;
   logic       ext_dir, blank_n, vid2_en;
   logic [1:0] meter_pulse;
   logic       tgen_blank_n = 1'b0, tile_sel = 1'b0, text_layer = 1'b0;
   logic [2:0] tile_bank;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   arcade_io_ctrl i_arcade_io_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .p1_in(p1_in),
      .p2_in(p2_in), .svc_in(svc_in), .dip1_in(dip1_in), .dip2_in(dip2_in),
      .ext_in(ext_in), .ext_out(ext_out), .ext_dir(ext_dir),
      .misc_out(misc_out), .meter_pulse(meter_pulse),
      .tgen_blank_n(tgen_blank_n), .blank_n(blank_n), .vid2_en(vid2_en),
      .tile_sel(tile_sel), .text_layer(text_layer), .tile_bank(tile_bank)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Write lands at the posedge between the two negedges.
   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   initial begin
      #150000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] old_m;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 misc_out", misc_out, 8'h00);
      check("R1 ext_out", ext_out, 8'h00);
      check("R1 ext_dir", {7'b0, ext_dir}, 8'h00);
      check("R1 vid2_en", {7'b0, vid2_en}, 8'h00);
      check("R1 meter_pulse", {6'b0, meter_pulse}, 8'h00);
      check("R1 blank_n", {7'b0, blank_n}, 8'h00);
      rd_check("R1 bank", 5'd7, 8'h00);
      rd_check("R1 ctl", 5'd8, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R3 input ports with several patterns
      for (int k = 0; k < 8; k++) begin
         logic [7:0] v;
         v = 8'(k * 37 + 5);
         p1_in = v; p2_in = ~v; dip1_in = v ^ 8'h5A; dip2_in = v + 8'd3; svc_in = v;
         rd_check("R2 p1", 5'd0, v);
         rd_check("R2 p2", 5'd1, ~v);
         rd_check("R2 dip1", 5'd5, v ^ 8'h5A);
         rd_check("R2 dip2", 5'd6, v + 8'd3);
         rd_check("R3 svc", 5'd4, {1'b1, v[6:0]});
      end
      svc_in = 8'h00;
      rd_check("R3 svc all low", 5'd4, 8'h80);
      // R2 writes to input ports ignored
      p1_in = 8'h12; p2_in = 8'h34; dip1_in = 8'h56; dip2_in = 8'h78;
      wr(5'd0, 8'hAA); wr(5'd1, 8'hAA); wr(5'd5, 8'hAA); wr(5'd6, 8'hAA); wr(5'd4, 8'hAA);
      rd_check("R2 p1 after write", 5'd0, 8'h12);
      rd_check("R2 p2 after write", 5'd1, 8'h34);
      rd_check("R2 dip1 after write", 5'd5, 8'h56);
      rd_check("R2 dip2 after write", 5'd6, 8'h78);
      check("R2 misc untouched", misc_out, 8'h00);
      check("R2 ext untouched", ext_out, 8'h00);

      // R4 bidirectional port
      ext_in = 8'hC3;
      wr(5'd2, 8'h69);
      check("R4 ext_out latch", ext_out, 8'h69);
      rd_check("R4 read input dir", 5'd2, 8'hC3);
      wr(5'd8, 8'h01);
      check("R4 ext_dir", {7'b0, ext_dir}, 8'h01);
      rd_check("R4 read output dir", 5'd2, 8'h69);
      wr(5'd2, 8'h96);
      rd_check("R4 read output dir 2", 5'd2, 8'h96);
      wr(5'd8, 8'h00);
      rd_check("R4 back to input", 5'd2, 8'hC3);

      // R8 control readback, R7 blank and vid2
      for (int c = 0; c < 8; c++) begin
         wr(5'd8, 8'(c) | 8'hF8);
         rd_check("R8 ctl readback", 5'd8, 8'(c));
         for (int t = 0; t < 2; t++) begin
            tgen_blank_n = t[0];
            #1;
            check("R7 blank_n", {7'b0, blank_n}, {7'b0, (c[1] | t[0])});
            check("R7 vid2_en", {7'b0, vid2_en}, {7'b0, c[2]});
         end
      end
      wr(5'd8, 8'h00);

      // R5 / R6 misc port and meter pulses across all transitions
      old_m = misc_out;
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            logic [7:0] d1, d2;
            d1 = {6'b011010, a[1:0]} ^ 8'h00;
            d2 = {6'b100101, b[1:0]};
            wr(5'd3, d1);
            check("R6 pulse after d1", {6'b0, meter_pulse}, {6'b0, d1[1:0] & ~old_m[1:0]});
            @(negedge clk);
            check("R6 pulse gone", {6'b0, meter_pulse}, 8'h00);
            wr(5'd3, d2);
            check("R6 pulse after d2", {6'b0, meter_pulse}, {6'b0, d2[1:0] & ~d1[1:0]});
            check("R5 misc_out", misc_out, d2);
            rd_check("R5 misc readback", 5'd3, d2);
            @(negedge clk);
            check("R6 pulse gone 2", {6'b0, meter_pulse}, 8'h00);
            old_m = d2;
         end
      end

      // R9 / R10 exhaustive tile bank sweep
      for (int v = 0; v < 256; v++) begin
         wr(5'd7, 8'(v));
         for (int s = 0; s < 4; s++) begin
            logic [3:0] nib;
            logic [2:0] expb;
            tile_sel = s[0]; text_layer = s[1];
            nib = (s[0] && !s[1]) ? 4'(v >> 4) : 4'(v);
            expb = nib[3] ? 3'd0 : nib[2:0];
            #1;
            check(nib[3] ? "R10 forced bank" : "R9 bank select", {5'b0, tile_bank}, {5'b0, expb});
         end
      end
      rd_check("R9 bank readback", 5'd7, 8'hFF);

      // R11 unmapped offsets
      wr(5'd3, 8'h5C); wr(5'd8, 8'h05); wr(5'd2, 8'h3A); wr(5'd7, 8'h21);
      for (int u = 9; u < 32; u++) begin
         wr(5'(u), 8'hFF);
         rd_check("R11 unmapped read", 5'(u), 8'h00);
      end
      rd_check("R11 misc kept", 5'd3, 8'h5C);
      rd_check("R11 ctl kept", 5'd8, 8'h05);
      rd_check("R11 bidir kept", 5'd2, 8'h3A);
      rd_check("R11 bank kept", 5'd7, 8'h21);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule